// File: doc/BRIEF.md
# Radix-4 SRT Mantissa Divider

This block divides one normalized mantissa by another. It uses radix-4 SRT recurrence, so each iteration yields one signed quotient digit in the range -2..+2. The partial remainder stays in redundant form, as a sum vector and a carry vector, and no carry has to ripple through it during the iterations. In each iteration both vectors are shifted left by two. A small adder then sums the top eight bits of the two shifted vectors. The lowest bit of that sum is discarded, which leaves a 7-bit remainder estimate. The estimate and the four divisor fraction bits that follow the leading one pick the next digit from a selection table. The chosen multiple of the divisor (0, ±d or ±2d) is then folded into the remainder by one row of carry-save adders.

Every table cell past the outermost boundary of a divisor row holds the saturated digit: +2 above the top boundary and -2 below the bottom one. No such cell holds zero. Positive and negative digits collect in two separate shift registers. When the iterations end, a single carry-propagate subtraction combines them, and the result drops by one if the final remainder is negative.

The block is driven through a start/busy handshake. The divider accepts operands while it is idle. It raises busy for the whole operation, and it pulses done once with the quotient on a held output. Exponents, rounding and special operands are handled outside the block.

Top module: `srt_divider`

## Requirements
- R1: With both operands W bits wide and their most significant bit set, the quotient equals floor(dividend · 4^(STEPS-1) / divisor), given as an unsigned 2·STEPS-bit value.
- R2: A start seen while busy is low is accepted at that clock edge. Busy is then high for STEPS+1 cycles. Done is high for exactly one cycle, in the cycle after the last busy cycle, and busy is low while done is high. A new start may be given in the same cycle as done.
- R3: The digit estimate is formed from the 8-bit sum of the top 8 bits (4 integer bits, 4 fraction bits) of the shifted sum and carry vectors, with the least significant bit dropped. The estimate never wraps, and it is at most 3/16 below the true shifted remainder.
- R4: Digit selection uses the estimate and divisor fraction bits [W-2 : W-5]. Each divisor row saturates: every estimate at or above the row's +1/+2 boundary gives +2, and every estimate below its -2/-1 boundary gives -2. Operand pairs whose estimate lands next to those boundaries divide correctly.
- R5: At every step the partial remainder w satisfies |w| ≤ (2/3)·d.
- R6: When the final remainder is negative, the quotient is one less than the difference of the digit sums. Exact divisions, such as equal operands, leave no correction.
- R7: A start given while busy is high has no effect on the result or the timing of the division in progress.
- R8: Reset clears busy, done and quotient. The quotient holds its value in every cycle in which done is low.
- R9: Every quotient lies in [2^(2·STEPS-3), 2^(2·STEPS-1)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a division; taken only while idle |
| dividend | input | MANT_W | Normalized dividend mantissa, MSB set |
| divisor | input | MANT_W | Normalized divisor mantissa, MSB set |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when the quotient is updated |
| quotient | output | 2*STEPS | Integer quotient, held until the next done |

## Verification
The checker tests three properties on every busy cycle: that the 7-bit estimate sits within its 3/16 window below the exact shifted remainder, that the remainder stays inside the two-thirds-of-divisor bound, and that done arrives after exactly STEPS+1 cycles with the quotient inside its range. A table cell that is wrong but never reached cannot be seen by any per-cycle property. Only the bench's directed pairs can show that the quotients are right. These include operands placed near each divisor row's upper boundary, equal and off-by-one operands that exercise the negative-remainder correction, and starts issued while a division is under way.

// File: rtl/srt_div_pkg.sv
package srt_div_pkg;

   localparam int EST_ADD_W = 8;   // width of the estimate adder
   localparam int EST_W     = 7;   // estimate bits used for selection (LSB dropped)
   localparam int REM_INT_W = 4;   // integer bits of the remainder, including sign

   typedef logic signed [2:0] qdig_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } div_state_t;

   // ceiling of num/den for den > 0
   function automatic int ceil_div(input int num, input int den);
      int q;
      q = num / den;
      if ((num % den != 0) && (num > 0)) q = q + 1;
      return q;
   endfunction

   // smallest estimate (units of 1/8) that selects a digit above k;
   // rowv is the divisor truncated to db fraction bits, scaled by 2^db
   function automatic int sel_bound(input int k, input int rowv, input int db);
      int den;
      den = 3 * (1 << db);
      if (k >= 0) return ceil_div(8 * (3 * k + 1) * (rowv + 1), den);
      else        return ceil_div(8 * (3 * k + 1) * rowv, den);
   endfunction

   // full selection function; out-of-range estimates saturate at +/-2
   function automatic int sel_digit(input int e, input int rowv, input int db);
      if (e >= sel_bound(1, rowv, db))  return 2;
      if (e >= sel_bound(0, rowv, db))  return 1;
      if (e >= sel_bound(-1, rowv, db)) return 0;
      if (e >= sel_bound(-2, rowv, db)) return -1;
      return -2;
   endfunction

endpackage

// File: rtl/srt_qsel.sv
module srt_qsel import srt_div_pkg::*; #(
   parameter int DIV_BITS = 4,
   parameter bit USE_ROM  = 1'b1
) (
   input  logic [EST_W-1:0]    est,
   input  logic [DIV_BITS-1:0] drow,
   output qdig_t               dig
);

   localparam int ROWS = 1 << DIV_BITS;
   localparam int COLS = 1 << EST_W;

   generate
      if (USE_ROM) begin : g_rom
         // full table, one cell per (divisor row, estimate)
         qdig_t rom [ROWS*COLS];
         for (genvar i = 0; i < ROWS*COLS; i++) begin : g_cell
            localparam int COL = i % COLS;
            localparam int EV  = (COL >= COLS/2) ? COL - COLS : COL;
            localparam int RV  = ROWS + i / COLS;
            assign rom[i] = qdig_t'(sel_digit(EV, RV, DIV_BITS));
         end
         assign dig = rom[{drow, est}];
      end else begin : g_cmp
         // four boundaries per row, compared against the estimate
         logic signed [EST_W-1:0] bnd [ROWS][4];
         logic signed [EST_W-1:0] est_s;
         for (genvar r = 0; r < ROWS; r++) begin : g_row
            for (genvar k = 0; k < 4; k++) begin : g_bnd
               assign bnd[r][k] = EST_W'(sel_bound(k - 2, ROWS + r, DIV_BITS));
            end
         end
         assign est_s = signed'(est);
         always_comb begin
            if (est_s >= bnd[drow][3])      dig = qdig_t'(2);
            else if (est_s >= bnd[drow][2]) dig = qdig_t'(1);
            else if (est_s >= bnd[drow][1]) dig = qdig_t'(0);
            else if (est_s >= bnd[drow][0]) dig = qdig_t'(-1);
            else                            dig = qdig_t'(-2);
         end
      end
   endgenerate

endmodule

// File: rtl/srt_step.sv
module srt_step import srt_div_pkg::*; #(
   parameter  int MANT_W   = 24,
   parameter  int DIV_BITS = 4,
   parameter  bit USE_ROM  = 1'b1,
   localparam int RW       = MANT_W + 5
) (
   input  logic [RW-1:0]     rem_s,
   input  logic [RW-1:0]     rem_c,
   input  logic [MANT_W-1:0] dvr,
   output logic [RW-1:0]     nxt_s,
   output logic [RW-1:0]     nxt_c,
   output logic [EST_W-1:0]  est,
   output qdig_t             dig
);

   logic [RW-1:0]        sh_s, sh_c, d1, d2, mag, addend, maj;
   logic [EST_ADD_W-1:0] est_sum;
   logic                 pos;

   assign sh_s = {rem_s[RW-3:0], 2'b00};
   assign sh_c = {rem_c[RW-3:0], 2'b00};

   // short adder on the top bits; its lowest bit is discarded
   assign est_sum = sh_s[RW-1 -: EST_ADD_W] + sh_c[RW-1 -: EST_ADD_W];
   assign est     = est_sum[EST_ADD_W-1:1];

   srt_qsel #(
      .DIV_BITS (DIV_BITS),
      .USE_ROM  (USE_ROM)
   ) u_qsel (
      .est  (est),
      .drow (dvr[MANT_W-2 -: DIV_BITS]),
      .dig  (dig)
   );

   // divisor aligned to the remainder format, and its double
   assign d1 = {3'b000, dvr, 2'b00};
   assign d2 = {2'b00, dvr, 3'b000};

   always_comb begin
      if (dig[1] && !dig[0]) mag = d2;
      else if (dig[0])       mag = d1;
      else                   mag = '0;
   end

   assign pos    = !dig[2] && (dig[1:0] != 2'b00);
   assign addend = pos ? ~mag : mag;

   // one carry-save row: shifted remainder plus the selected multiple
   assign maj   = (sh_s & sh_c) | (sh_s & addend) | (sh_c & addend);
   assign nxt_s = sh_s ^ sh_c ^ addend;
   assign nxt_c = {maj[RW-2:0], pos};

endmodule

// File: rtl/srt_qacc.sv
module srt_qacc import srt_div_pkg::*; #(
   parameter int QW = 26
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          shift,
   input  qdig_t         dig,
   input  logic          rem_neg,
   output logic [QW-1:0] q_res
);

   logic [QW-1:0] qp, qn;
   logic [2:0]    neg_dig;
   logic [1:0]    mag;

   assign neg_dig = -dig;
   assign mag     = dig[2] ? neg_dig[1:0] : dig[1:0];

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         qp <= '0;
         qn <= '0;
      end else if (shift) begin
         qp <= {qp[QW-3:0], (dig[2] ? 2'b00 : mag)};
         qn <= {qn[QW-3:0], (dig[2] ? mag : 2'b00)};
      end
   end

   // single carry-propagate step, with the negative-remainder correction
   assign q_res = qp - qn - QW'(rem_neg);

endmodule

// File: rtl/srt_divider.sv
module srt_divider import srt_div_pkg::*; #(
   parameter  int MANT_W   = 24,
   parameter  int STEPS    = 13,
   parameter  int DIV_BITS = 4,
   parameter  bit USE_ROM  = 1'b1,
   localparam int QW       = 2 * STEPS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [MANT_W-1:0] dividend,
   input  logic [MANT_W-1:0] divisor,
   output logic              busy,
   output logic              done,
   output logic [QW-1:0]     quotient
);

   localparam int RW    = MANT_W + 5;
   localparam int CNT_W = $clog2(STEPS);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

   generate
      if (DIV_BITS < 4 || DIV_BITS > 6) begin : g_bad_div_bits
         $error("srt_divider: DIV_BITS must be within 4..6");
      end
      if (MANT_W < DIV_BITS + 2) begin : g_bad_mant_w
         $error("srt_divider: MANT_W too narrow for DIV_BITS");
      end
      if (STEPS < 3) begin : g_bad_steps
         $error("srt_divider: STEPS must be at least 3");
      end
   endgenerate

   div_state_t        state;
   logic [CNT_W-1:0]  cnt;
   logic [RW-1:0]     rem_s, rem_c, nxt_s, nxt_c, rem_tot;
   logic [MANT_W-1:0] dvr;
   logic [EST_W-1:0]  est_w;
   qdig_t             dig;
   logic [QW-1:0]     q_res, quo_q;
   logic              done_q, accept;

   assign accept = (state == ST_IDLE) && start;

   srt_step #(
      .MANT_W   (MANT_W),
      .DIV_BITS (DIV_BITS),
      .USE_ROM  (USE_ROM)
   ) u_step (
      .rem_s (rem_s),
      .rem_c (rem_c),
      .dvr   (dvr),
      .nxt_s (nxt_s),
      .nxt_c (nxt_c),
      .est   (est_w),
      .dig   (dig)
   );

   assign rem_tot = rem_s + rem_c;

   srt_qacc #(
      .QW (QW)
   ) u_qacc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (accept),
      .shift   (state == ST_RUN),
      .dig     (dig),
      .rem_neg (rem_tot[RW-1]),
      .q_res   (q_res)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         rem_s  <= '0;
         rem_c  <= '0;
         dvr    <= '0;
         quo_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  rem_s <= {{(RW-MANT_W){1'b0}}, dividend};  // dividend / 4
                  rem_c <= '0;
                  dvr   <= divisor;
                  cnt   <= '0;
                  state <= ST_RUN;
               end
            end
            ST_RUN: begin
               rem_s <= nxt_s;
               rem_c <= nxt_c;
               cnt   <= cnt + 1'b1;
               if (cnt == LAST) state <= ST_FIN;
            end
            ST_FIN: begin
               quo_q  <= q_res;
               done_q <= 1'b1;
               state  <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state != ST_IDLE);
   assign done     = done_q;
   assign quotient = quo_q;

endmodule

// File: rtl/srt_divider_chk.sv
module srt_divider_chk import srt_div_pkg::*; #(
   parameter  int MANT_W = 24,
   parameter  int STEPS  = 13,
   localparam int RW     = MANT_W + 5,
   localparam int FR     = MANT_W + 1,
   localparam int QW     = 2 * STEPS
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic [QW-1:0]     quotient,
   input logic [RW-1:0]     rem_s,
   input logic [RW-1:0]     rem_c,
   input logic [MANT_W-1:0] dvr,
   input logic [EST_W-1:0]  est
);

   logic [RW-1:0] rsum;
   longint        w_val, w_abs, d_val, gap;
   int            run_cnt;

   always_comb begin
      rsum  = rem_s + rem_c;
      w_val = longint'(signed'(rsum));
      w_abs = (w_val < 0) ? -w_val : w_val;
      d_val = longint'(dvr);
      gap   = 4 * w_val - longint'(signed'(est)) * (longint'(1) << (FR - 3));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)              run_cnt <= 0;
      else if (!busy && start) run_cnt <= 0;
      else if (busy)           run_cnt <= run_cnt + 1;
   end

   // R3: estimate sits in [0, 3/16) below the exact shifted remainder
   p_est_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (gap >= 0 && gap < 3 * (longint'(1) << (FR - 4))));

   // R5: |w| <= 2/3 d, written as 3|w| <= 8D in integer units
   p_rem_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (3 * w_abs <= 8 * d_val));

   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (run_cnt == STEPS + 1));

   p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(quotient));

   p_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!quotient[QW-1] && (quotient[QW-2:QW-3] != 2'b00)));

endmodule

bind srt_divider srt_divider_chk #(
   .MANT_W (MANT_W),
   .STEPS  (STEPS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .done     (done),
   .quotient (quotient),
   .rem_s    (rem_s),
   .rem_c    (rem_c),
   .dvr      (dvr),
   .est      (est_w)
);

// File: tb/srt_divider_test.sv
module srt_divider_test;

   localparam int MANT_W   = 24;
   localparam int STEPS    = 13;
   localparam int QW       = 2 * STEPS;
   localparam int CLK_HALF = 5;
   localparam int WDOG     = 150000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [MANT_W-1:0] dividend_i = '0;
   logic [MANT_W-1:0] divisor_i = '0;
   logic              busy, done;
   logic [QW-1:0]     quotient;

   int     checks = 0;
   int     errors = 0;
   int     cyc = 0;
   string  cur_tag = "R1";

   // behavioural model state
   longint exp_q[$];
   string  tag_q[$];
   int     m_cnt = 0;
   bit     m_done = 1'b0;
   longint m_quo = 0;
   string  m_tag = "R1";

   srt_divider #(.MANT_W(MANT_W), .STEPS(STEPS)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .dividend (dividend_i),
      .divisor  (divisor_i),
      .busy     (busy),
      .done     (done),
      .quotient (quotient)
   );

   always #CLK_HALF clk = ~clk;

   function automatic longint ref_quo(input longint a, input longint b);
      return (a << (2 * (STEPS - 1))) / b;
   endfunction

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // model: advances on the clock edge from stable inputs
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_done = 1'b0; m_quo = 0;
         exp_q.delete(); tag_q.delete();
      end else begin
         m_done = 1'b0;
         if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) begin
               m_done = 1'b1;
               m_quo  = exp_q.pop_front();
               m_tag  = tag_q.pop_front();
            end
         end else if (start) begin
            exp_q.push_back(ref_quo(longint'(dividend_i), longint'(divisor_i)));
            tag_q.push_back(cur_tag);
            m_cnt = STEPS + 1;
         end
      end
   end

   // compare away from the active edge, every cycle
   always @(negedge clk) begin
      if (rst_n) begin
         check((busy === (m_cnt > 0)) && (done === m_done), "R2",
               longint'({busy, done}), longint'({(m_cnt > 0), m_done}));
         if (m_done)
            check(longint'(quotient) == m_quo, m_tag, longint'(quotient), m_quo);
         else
            check(longint'(quotient) == m_quo, "R8", longint'(quotient), m_quo);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > WDOG) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WDOG);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // caller sits at a negedge; returns at the negedge where done is visible
   task automatic run_div(input longint a, input longint b, input string tag);
      dividend_i = MANT_W'(a);
      divisor_i  = MANT_W'(b);
      cur_tag    = tag;
      start      = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (STEPS + 1) @(negedge clk);
   endtask

   function automatic longint clampx(input longint v);
      longint lo, hi;
      lo = longint'(1) << (MANT_W - 1);
      hi = (longint'(1) << MANT_W) - 1;
      return (v < lo) ? lo : ((v > hi) ? hi : v);
   endfunction

   initial begin
      longint lo, hi, d, x;
      lo = longint'(1) << (MANT_W - 1);
      hi = (longint'(1) << MANT_W) - 1;

      repeat (4) @(negedge clk);
      // R8: reset state
      check(busy === 1'b0 && done === 1'b0 && quotient === '0, "R8",
            longint'({busy, done}) + longint'(quotient), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: extreme operand pairs
      run_div(hi, lo, "R9");
      run_div(lo, hi, "R9");
      run_div(hi, hi, "R9");
      // R6: exact and off-by-one operands (correction boundary)
      run_div(lo, lo, "R6");
      for (int i = 0; i < 6; i++) begin
         d = lo + 1 + longint'(i) * 1234567;
         run_div(d, d, "R6");
         run_div(d - 1, d, "R6");
         run_div(d + 1, d, "R6");
      end

      // R3/R4: divisors at each row's edges, dividends near the digit boundaries
      for (int r = 0; r < 16; r++) begin
         for (int e = 0; e < 2; e++) begin
            d = lo | (longint'(r) << (MANT_W - 5));
            if (e == 1) d = d | ((longint'(1) << (MANT_W - 5)) - 1);
            for (int k = -2; k <= 2; k += 2) begin
               x = clampx((d * 4) / 3 + k);
               run_div(x, d, "R4");
            end
            run_div(clampx((d * 5) / 3), d, "R3");
            run_div(clampx((d * 7) / 6), d, "R4");
         end
      end

      // R7: starts while busy must be ignored
      for (int i = 0; i < 3; i++) begin
         dividend_i = MANT_W'(lo + 777 * (i + 1));
         divisor_i  = MANT_W'(hi - 4321 * (i + 1));
         cur_tag    = "R7";
         start      = 1'b1;
         @(negedge clk);
         start = 1'b0;
         repeat (3) @(negedge clk);
         dividend_i = MANT_W'(hi);
         divisor_i  = MANT_W'(lo);
         start      = 1'b1;
         repeat (2) @(negedge clk);
         start = 1'b0;
         repeat (STEPS - 4) @(negedge clk);
      end

      // R1/R5: random normalized operands
      for (int i = 0; i < 300; i++) begin
         x = longint'($urandom) & hi;
         d = longint'($urandom) & hi;
         run_div(x | lo, d | lo, "R1/R5");
      end

      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule